// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Flags

This block is a byte-addressed peripheral holding two 16-bit down-counters and a small interrupt controller. The first counter runs freely: it counts down from a loaded value, passes through zero to all-ones, and then reloads from a 16-bit latch. The second counter is a one-shot. It is loaded in one step from a stored low byte and a written high byte. It raises its flag once per load and keeps counting after that.

Software drives the block through a 4-bit address, separate write and read strobes, and 8-bit data paths. Read data is combinational from the addressed register. Side effects of a read take place at the clock edge that ends the read cycle. Both counters advance only in cycles where the tick enable input is high. A seven-bit flag register and a seven-bit enable register are combined into one active-high interrupt line. Several register accesses also set or clear flags as a side effect.

Top module: `dual_timer_irq`

## Requirements
- R1: Counter 1 moves only on cycles with `tick_en` high. From a loaded value L it steps L, L-1, ..., 0, then 0xFFFF, then reloads L, so its free-running period is L+2 ticks.
- R2: Flag bit 6 (value 0x40) is set on every tick that brings counter 1 to 0, including a reload from a latch of 0.
- R3: A write to address 4 replaces only the low byte of the counter 1 latch and leaves the counter unchanged. A write to address 5 replaces the latch high byte, clears flag bit 6 and loads counter 1 from the whole new latch.
- R4: Writes to addresses 6 and 7 replace the latch low and high bytes without loading the counter. A write to address 7 also clears flag bit 6. Reads of addresses 6 and 7 return the latch low and high bytes.
- R5: Reads of addresses 4/5 return counter 1 low/high bytes. Reads of addresses 8/9 return counter 2 low/high bytes.
- R6: A write to address 8 stores a byte as the counter 2 low latch. A write to address 9 loads counter 2 with {written byte, low latch}. A read of address 8 clears flag bit 5 (value 0x20).
- R7: Counter 2 decrements on every tick and wraps from 0 to 0xFFFF. It sets flag bit 5 only on its first arrival at 0 after each address 9 load.
- R8: A read of address 13 returns flags in bits 6..0. Bit 7 is 1 exactly when some flag and its enable are both 1.
- R9: A write to address 14 with bit 7 = 1 sets the enables selected by bits 6..0. With bit 7 = 0 it clears the selected enables. A read of address 14 returns the enables with bit 7 forced to 1.
- R10: A write to address 13 clears every flag whose bit is written as 1 and leaves the other flags unchanged.
- R11: `irq` is high exactly when some flag bit and its enable bit are both 1.
- R12: After reset, the counter 1 latch and counter are 0xFFFF, the counter 2 low latch is 0, the counter 2 counter is 0xFFFF, and flags and enables are 0.
- R13: Address 10 holds a byte that reads back as written. Addresses 0-3, 11, 12 and 15 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, acts at the rising edge |
| rd_en | input | 1 | Read strobe, read side effects act at the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| tick_en | input | 1 | Counting enable for both counters |
| irq | output | 1 | Active-high interrupt request |

## Verification
A wrong wrap flag in counter 1 shows on the very next tick. The counter either reloads one tick early or falls below 0xFFFF, so reading address 4/5 right after a pass through zero exposes it at once. A one-shot state left armed after the first hit is only visible a full 65536 ticks later, as a second flag. For that reason the bench runs counter 2 through a complete wrap. Flag and enable errors reach `irq` and the address 13 summary bit in the cycle after the event that caused them.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int FLAG_W = 7;
  localparam int ADDR_W = 4;
  localparam int T1_BIT = 6;
  localparam int T2_BIT = 5;

  typedef enum logic [3:0] {
    A_T1_CNT_LO = 4'd4,
    A_T1_CNT_HI = 4'd5,
    A_T1_LAT_LO = 4'd6,
    A_T1_LAT_HI = 4'd7,
    A_T2_LO     = 4'd8,
    A_T2_HI     = 4'd9,
    A_SHIFT     = 4'd10,
    A_FLAGS     = 4'd13,
    A_ENABLE    = 4'd14
  } reg_addr_e;
endpackage

// File: rtl/dtmr_reload_timer.sv
module dtmr_reload_timer #(
  parameter int BYTE_W = dtmr_pkg::BYTE_W,
  parameter int CNT_W  = dtmr_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              lat_lo_we,
  input  logic              lat_hi_we,
  input  logic              load_we,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [CNT_W-1:0]  latch_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              hit_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] latch_q, latch_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;
  logic             hit;

  always_comb begin
    latch_d = latch_q;
    if (lat_lo_we) latch_d[BYTE_W-1:0]     = wbyte;
    if (lat_hi_we) latch_d[CNT_W-1:BYTE_W] = wbyte;
  end

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    hit    = 1'b0;
    if (load_we) begin
      cnt_d  = latch_d;
      wrap_d = 1'b0;
    end else if (tick) begin
      if (wrap_q) begin
        cnt_d  = latch_q;
        wrap_d = 1'b0;
        hit    = (latch_q == '0);
      end else if (cnt_q == '0) begin
        cnt_d  = ALL_ONES;
        wrap_d = 1'b1;
      end else begin
        cnt_d  = cnt_q - ONE;
        hit    = (cnt_q == ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= ALL_ONES;
      cnt_q   <= ALL_ONES;
      wrap_q  <= 1'b0;
    end else begin
      if (lat_lo_we || lat_hi_we) latch_q <= latch_d;
      if (load_we || tick) begin
        cnt_q  <= cnt_d;
        wrap_q <= wrap_d;
      end
    end
  end

  assign latch_o = latch_q;
  assign count_o = cnt_q;
  assign hit_o   = hit;

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_we && !wrap_q && cnt_q == '0) |=> (cnt_q == ALL_ONES));
  assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_we && wrap_q) |=> (cnt_q == $past(latch_q)));
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (cnt_q == latch_q && !wrap_q));
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_we) |=> $stable(cnt_q));
endmodule

// File: rtl/dtmr_oneshot_timer.sv
module dtmr_oneshot_timer #(
  parameter int BYTE_W = dtmr_pkg::BYTE_W,
  parameter int CNT_W  = dtmr_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              lo_we,
  input  logic              load_we,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [CNT_W-1:0]  count_o,
  output logic              hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              armed_q, armed_d;
  logic              hit;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    hit     = 1'b0;
    if (load_we) begin
      cnt_d   = {wbyte, lo_q};
      armed_d = 1'b1;
    end else if (tick) begin
      cnt_d = cnt_q - ONE;
      if (armed_q && cnt_q == ONE) begin
        hit     = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      cnt_q   <= {CNT_W{1'b1}};
      armed_q <= 1'b0;
    end else begin
      if (lo_we) lo_q <= wbyte;
      if (load_we || tick) begin
        cnt_q   <= cnt_d;
        armed_q <= armed_d;
      end
    end
  end

  assign count_o = cnt_q;
  assign hit_o   = hit;

  assert_single_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !armed_q);
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (cnt_q == {$past(wbyte), $past(lo_q)} && armed_q));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_we && cnt_q == '0) |=> (cnt_q == {CNT_W{1'b1}}));
endmodule

// File: rtl/dtmr_irq_ctl.sv
module dtmr_irq_ctl #(
  parameter int BYTE_W = dtmr_pkg::BYTE_W,
  parameter int FLAG_W = dtmr_pkg::FLAG_W,
  parameter int T1_BIT = dtmr_pkg::T1_BIT,
  parameter int T2_BIT = dtmr_pkg::T2_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t1_hit,
  input  logic              t2_hit,
  input  logic              t1_clr,
  input  logic              t2_clr,
  input  logic              flag_we,
  input  logic              ena_we,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] ena_o,
  output logic              irq_o
);
  localparam int SEL_BIT = BYTE_W - 1;

  logic [FLAG_W-1:0] flags_q, flags_d, ena_q, ena_d;
  logic [FLAG_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[T1_BIT] = t1_hit;
    set_vec[T2_BIT] = t2_hit;
    if (flag_we) clr_vec = wbyte[FLAG_W-1:0];
    if (t1_clr)  clr_vec[T1_BIT] = 1'b1;
    if (t2_clr)  clr_vec[T2_BIT] = 1'b1;
    flags_d = (flags_q & ~clr_vec) | set_vec;
  end

  always_comb begin
    ena_d = ena_q;
    if (ena_we) begin
      if (wbyte[SEL_BIT]) ena_d = ena_q | wbyte[FLAG_W-1:0];
      else                ena_d = ena_q & ~wbyte[FLAG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ena_q   <= '0;
    end else begin
      flags_q <= flags_d;
      if (ena_we) ena_q <= ena_d;
    end
  end

  assign flags_o = flags_q;
  assign ena_o   = ena_q;
  assign irq_o   = |(flags_q & ena_q);

  assert_t1_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    t1_hit |=> flags_q[T1_BIT]);
  assert_t2_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    t2_hit |=> flags_q[T2_BIT]);
  assert_ena_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_we && wbyte[SEL_BIT]) |=>
      ((ena_q & $past(wbyte[FLAG_W-1:0])) == $past(wbyte[FLAG_W-1:0])));
  assert_ena_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_we && !wbyte[SEL_BIT]) |=> ((ena_q & $past(wbyte[FLAG_W-1:0])) == '0));
  assert_flag_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && wbyte[T2_BIT] && !t2_hit) |=> !flags_q[T2_BIT]);
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !irq_o);
endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq #(
  parameter int ADDR_W = dtmr_pkg::ADDR_W,
  parameter int BYTE_W = dtmr_pkg::BYTE_W,
  parameter int CNT_W  = dtmr_pkg::CNT_W,
  parameter int FLAG_W = dtmr_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              tick_en,
  output logic              irq
);
  import dtmr_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [CNT_W-1:0]  t1_latch, t1_cnt, t2_cnt;
  logic              t1_hit, t2_hit;
  logic [FLAG_W-1:0] flags, ena;
  logic [BYTE_W-1:0] shift_q;
  logic              irq_int;

  logic wr_t1_lo, wr_t1_hi_ld, wr_t1_lat_lo, wr_t1_lat_hi;
  logic wr_t2_lo, wr_t2_hi, wr_shift, wr_flags, wr_ena, rd_t2_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign wr_t1_lo     = wr_en && (addr == A_T1_CNT_LO);
  assign wr_t1_hi_ld  = wr_en && (addr == A_T1_CNT_HI);
  assign wr_t1_lat_lo = wr_en && (addr == A_T1_LAT_LO);
  assign wr_t1_lat_hi = wr_en && (addr == A_T1_LAT_HI);
  assign wr_t2_lo     = wr_en && (addr == A_T2_LO);
  assign wr_t2_hi     = wr_en && (addr == A_T2_HI);
  assign wr_shift     = wr_en && (addr == A_SHIFT);
  assign wr_flags     = wr_en && (addr == A_FLAGS);
  assign wr_ena       = wr_en && (addr == A_ENABLE);
  assign rd_t2_lo     = rd_en && (addr == A_T2_LO);

  dtmr_reload_timer #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_t1 (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .tick      (tick_en),
    .lat_lo_we (wr_t1_lo || wr_t1_lat_lo),
    .lat_hi_we (wr_t1_hi_ld || wr_t1_lat_hi),
    .load_we   (wr_t1_hi_ld),
    .wbyte     (wdata),
    .latch_o   (t1_latch),
    .count_o   (t1_cnt),
    .hit_o     (t1_hit)
  );

  dtmr_oneshot_timer #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_t2 (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (tick_en),
    .lo_we   (wr_t2_lo),
    .load_we (wr_t2_hi),
    .wbyte   (wdata),
    .count_o (t2_cnt),
    .hit_o   (t2_hit)
  );

  dtmr_irq_ctl #(.BYTE_W(BYTE_W), .FLAG_W(FLAG_W)) u_irq (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .t1_hit  (t1_hit),
    .t2_hit  (t2_hit),
    .t1_clr  (wr_t1_hi_ld || wr_t1_lat_hi),
    .t2_clr  (rd_t2_lo),
    .flag_we (wr_flags),
    .ena_we  (wr_ena),
    .wbyte   (wdata),
    .flags_o (flags),
    .ena_o   (ena),
    .irq_o   (irq_int)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)   shift_q <= '0;
    else if (wr_shift) shift_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_T1_CNT_LO: rdata = t1_cnt[BYTE_W-1:0];
      A_T1_CNT_HI: rdata = t1_cnt[CNT_W-1:BYTE_W];
      A_T1_LAT_LO: rdata = t1_latch[BYTE_W-1:0];
      A_T1_LAT_HI: rdata = t1_latch[CNT_W-1:BYTE_W];
      A_T2_LO:     rdata = t2_cnt[BYTE_W-1:0];
      A_T2_HI:     rdata = t2_cnt[CNT_W-1:BYTE_W];
      A_SHIFT:     rdata = shift_q;
      A_FLAGS:     rdata = {irq_int, flags};
      A_ENABLE:    rdata = {1'b1, ena};
      default:     rdata = '0;
    endcase
  end

  assign irq = irq_int;

  assert_summary_bit_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (addr == A_FLAGS) |-> (rdata[BYTE_W-1] == irq));
  assert_t1_flag_clear_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_t1_hi_ld && !t1_hit) |=> !flags[T1_BIT]);
endmodule

// File: tb/dual_timer_irq_tb.sv
module dual_timer_irq_tb;
  logic       clk;
  logic       rst_n;
  logic [3:0] addr;
  logic       wr_en, rd_en, tick_en;
  logic [7:0] wdata, rdata;
  logic       irq;
  int n_run, n_fail;
  bit done;

  dual_timer_irq u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic irqchk(input string tag, input logic exp);
    @(negedge clk);
    #2 chk(tag, {15'h0, irq}, {15'h0, exp});
  endtask

  task automatic t_reset;
    rchk("R12 t1 cnt lo", 4'd4, 8'hFF);
    rchk("R12 t1 cnt hi", 4'd5, 8'hFF);
    rchk("R12 t1 lat lo", 4'd6, 8'hFF);
    rchk("R12 t1 lat hi", 4'd7, 8'hFF);
    rchk("R12 t2 cnt lo", 4'd8, 8'hFF);
    rchk("R12 t2 cnt hi", 4'd9, 8'hFF);
    rchk("R12 flags", 4'd13, 8'h00);
    rchk("R12 enables", 4'd14, 8'h80);
    irqchk("R12 irq", 1'b0);
  endtask

  task automatic t_t1_period;
    wr(4'd4, 8'h03);
    wr(4'd5, 8'h00);
    rchk("R3 load lo", 4'd4, 8'h03);
    ticks(3);
    rchk("R1 at zero", 4'd4, 8'h00);
    rchk("R2 flag set", 4'd13, 8'h40);
    irqchk("R11 masked irq", 1'b0);
    ticks(1);
    rchk("R1 wrap lo", 4'd4, 8'hFF);
    rchk("R1 wrap hi", 4'd5, 8'hFF);
    ticks(1);
    rchk("R1 reload", 4'd4, 8'h03);
    wr(4'd13, 8'h40);
    rchk("R10 clear", 4'd13, 8'h00);
    ticks(3);
    rchk("R2 second period", 4'd13, 8'h40);
  endtask

  task automatic t_latch_regs;
    wr(4'd7, 8'h00);
    rchk("R4 no restart", 4'd4, 8'h00);
    rchk("R4 flag clr", 4'd13, 8'h00);
    wr(4'd6, 8'h10);
    rchk("R4 lat lo cnt kept", 4'd4, 8'h00);
    rchk("R4 lat lo read", 4'd6, 8'h10);
    ticks(2);
    rchk("R1 reload new latch lo", 4'd4, 8'h10);
    rchk("R1 reload new latch hi", 4'd5, 8'h00);
    rchk("R2 no flag nonzero", 4'd13, 8'h00);
    wr(4'd4, 8'h55);
    rchk("R3 addr4 cnt kept", 4'd4, 8'h10);
    rchk("R3 addr4 latch lo", 4'd6, 8'h55);
    rchk("R4 lat hi read", 4'd7, 8'h00);
  endtask

  task automatic t_enables;
    wr(4'd14, 8'hC0);
    rchk("R9 set", 4'd14, 8'hC0);
    wr(4'd14, 8'h22);
    rchk("R9 clear", 4'd14, 8'hC0);
    wr(4'd14, 8'hA1);
    rchk("R9 set two", 4'd14, 8'hE1);
    wr(4'd14, 8'h01);
    rchk("R9 clear one", 4'd14, 8'hE0);
  endtask

  task automatic t_irq;
    wr(4'd4, 8'h02);
    wr(4'd5, 8'h00);
    ticks(2);
    irqchk("R11 irq high", 1'b1);
    rchk("R8 summary bit", 4'd13, 8'hC0);
    wr(4'd13, 8'h40);
    irqchk("R11 irq low", 1'b0);
    rchk("R10 flags clear", 4'd13, 8'h00);
  endtask

  task automatic t_oneshot;
    logic [7:0] v;
    wr(4'd4, 8'hFF);
    wr(4'd5, 8'hFF);
    wr(4'd8, 8'h04);
    wr(4'd9, 8'h00);
    rchk("R6 load hi", 4'd9, 8'h00);
    rchk("R5 t2 lo", 4'd8, 8'h04);
    ticks(4);
    irqchk("R11 t2 irq", 1'b1);
    rchk("R7 t2 flag", 4'd13, 8'hA0);
    rchk("R6 read clears", 4'd8, 8'h00);
    rchk("R6 flag gone", 4'd13, 8'h00);
    ticks(65536);
    rd(4'd13, v);
    chk("R7 no refire", {8'h00, v & 8'h20}, 16'h0000);
    chk("R2 t1 wrapped", {8'h00, v}, 16'h00C0);
    rchk("R7 t2 wrapped lo", 4'd8, 8'h00);
    rchk("R7 t2 wrapped hi", 4'd9, 8'h00);
    rchk("R1 t1 after reload", 4'd4, 8'hFC);
    wr(4'd9, 8'h00);
    ticks(4);
    rchk("R7 rearmed", 4'd13, 8'hE0);
    wr(4'd13, 8'h20);
    rchk("R10 selective", 4'd13, 8'hC0);
    wr(4'd13, 8'h40);
    rchk("R10 all clear", 4'd13, 8'h00);
  endtask

  task automatic t_misc;
    wr(4'd10, 8'h5A);
    rchk("R13 shift byte", 4'd10, 8'h5A);
    wr(4'd2, 8'hFF);
    wr(4'd11, 8'hFF);
    rchk("R13 unmapped 2", 4'd2, 8'h00);
    rchk("R13 unmapped 11", 4'd11, 8'h00);
    rchk("R13 enables kept", 4'd14, 8'hE0);
    rchk("R13 flags kept", 4'd13, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; addr = '0; wdata = '0;
    wr_en = 1'b0; rd_en = 1'b0; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_t1_period();
    t_latch_regs();
    t_enables();
    t_irq();
    t_oneshot();
    t_misc();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule